// File: doc/BRIEF.md
# Oscillator Query Configuration Registers

This block is a small memory-mapped slave with 32-bit registers. Software uses it to ask a board-level configuration space for fixed facts. There are three registers: a data word, a control word and a status word. Software loads the control word with a packed request that has its start bit set. For a read of the oscillator function, the block takes the target site and device from the request, looks up a fixed clock frequency in hertz, and places it in the data word. Software then reads the result back from the data word.

Write requests to the configuration space are accepted and discarded. Requests aimed at other functions, controllers or positions, or at sites that do not exist, leave the data word as it was. The lookup completes within the cycle of the control write, so the block is never busy. The control word always reads back as zero and the status word always reads back as one. A single-cycle pulse marks each started request.

The bus side is a plain synchronous port with an address, a write enable, write data and registered read data that arrives one cycle after the address.

Top module: `osc_query_regs`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the data word is 0, the read data is 0 and the request pulse is 0.
- R2: A bus write to byte offset 0xA0 stores all 32 bits in the data word. A read at 0xA0 returns the stored value one clock after the address is presented.
- R3: A read of the control word at 0xA4 returns 0. A read of the status word at 0xA8 returns 1.
- R4: A read at any other offset returns 0. A write to any other offset, or to 0xA8, leaves the data word unchanged.
- R5: The control word carries these fields: device in bits 11:0, position in bits 15:12, site in bits 17:16, function in bits 25:20, controller index in bits 29:26, write flag in bit 30 and start flag in bit 31. For a started read with index 0, position 0, function 1 and site 0, the data word becomes 25000000 for device 0 or 1, 24000000 for device 2, and 0 for every other device.
- R6: For a started read with index 0, position 0, function 1 and site 1, the data word becomes one of these values. Devices 0 and 5 give 50000000. Devices 4, 7 and 8 give 40000000. Device 6 gives 35000000. Every other device gives 0.
- R7: A started read that addresses site 2 or site 3 leaves the data word unchanged.
- R8: A started read with a nonzero controller index, a nonzero position, or a function other than 1 leaves the data word unchanged.
- R9: A control write with bit 31 clear has no effect on the data word and produces no request pulse.
- R10: A control write with bits 31 and 30 both set is accepted: it produces a request pulse, but the data word is left unchanged.
- R11: Each control write with bit 31 set raises the request pulse for exactly the one cycle that follows the write edge. The updated data word is visible from that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| req_pulse | output | 1 | One-cycle flag for each started control request |

## Verification
Register writes and control-word lookups take effect on the clock edge where the write is presented. The request pulse is high during the cycle right after that edge. Read data comes one edge later than the address. To match this, the bench drives inputs on falling edges. It samples the pulse on the falling edge that follows the write edge. It samples read data on the falling edge that follows the edge on which the address was held. Every lookup vector first preloads a sentinel into the data word, so that a result of "unchanged" can be told apart from a lookup that returns zero.

// File: rtl/osc_query_regs.sv
module osc_query_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DATA = 'hA0,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'hA4,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_pulse
);

  localparam logic [31:0] HZ_25M = 32'd25_000_000;
  localparam logic [31:0] HZ_24M = 32'd24_000_000;
  localparam logic [31:0] HZ_50M = 32'd50_000_000;
  localparam logic [31:0] HZ_40M = 32'd40_000_000;
  localparam logic [31:0] HZ_35M = 32'd35_000_000;

  logic [31:0] data_q;

  wire        wr_data = bus_we && (bus_addr == OFS_DATA);
  wire        wr_ctrl = bus_we && (bus_addr == OFS_CTRL);

  wire [11:0] f_dev   = bus_wdata[11:0];
  wire [3:0]  f_pos   = bus_wdata[15:12];
  wire [1:0]  f_site  = bus_wdata[17:16];
  wire [5:0]  f_func  = bus_wdata[25:20];
  wire [3:0]  f_idx   = bus_wdata[29:26];
  wire        f_write = bus_wdata[30];
  wire        f_start = bus_wdata[31];

  wire is_osc_read = wr_ctrl && f_start && !f_write &&
                     (f_idx == 4'd0) && (f_pos == 4'd0) && (f_func == 6'd1);

  logic        hit;
  logic [31:0] freq;

  always_comb begin
    hit  = 1'b1;
    freq = 32'd0;
    unique case (f_site)
      2'd0: begin
        case (f_dev)
          12'd0, 12'd1: freq = HZ_25M;
          12'd2:        freq = HZ_24M;
          default:      freq = 32'd0;
        endcase
      end
      2'd1: begin
        case (f_dev)
          12'd0, 12'd5:        freq = HZ_50M;
          12'd4, 12'd7, 12'd8: freq = HZ_40M;
          12'd6:               freq = HZ_35M;
          default:             freq = 32'd0;
        endcase
      end
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= 32'd0;
      req_pulse <= 1'b0;
    end else begin
      req_pulse <= wr_ctrl && f_start;
      if (wr_data)
        data_q <= bus_wdata;
      else if (is_osc_read && hit)
        data_q <= freq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= 32'd0;
    else if (bus_addr == OFS_DATA)
      bus_rdata <= data_q;
    else if (bus_addr == OFS_STAT)
      bus_rdata <= 32'd1;
    else
      bus_rdata <= 32'd0;
  end

  // R2
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_DATA) |=> data_q == $past(bus_wdata));

  // R3
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_STAT) |=> bus_rdata == 32'd1);

  // R3
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |=> bus_rdata == 32'd0);

  // R4
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == OFS_DATA || bus_addr == OFS_CTRL)) |=> $stable(data_q));

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && !bus_wdata[31]) |=> ($stable(data_q) && !req_pulse));

  // R10
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && bus_wdata[31] && bus_wdata[30]) |=> ($stable(data_q) && req_pulse));

  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFS_CTRL) |=> !req_pulse);

endmodule

// File: tb/osc_query_regs_tb.sv
module osc_query_regs_tb;

  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;
  localparam logic [31:0] SENT  = 32'hDEADBEEF;
  localparam int NV = 20;

  // {control word, expected data word (SENT = unchanged)}
  localparam logic [63:0] VEC [NV] = '{
    {32'h8010_0000, 32'd25000000},  // R5 site0 dev0
    {32'h8010_0001, 32'd25000000},  // R5 site0 dev1
    {32'h8010_0002, 32'd24000000},  // R5 site0 dev2
    {32'h8010_0003, 32'd0},         // R5 site0 unknown dev
    {32'h8010_0800, 32'd0},         // R5 upper device bit
    {32'h8011_0000, 32'd50000000},  // R6 site1 dev0
    {32'h8011_0001, 32'd0},         // R6 site1 unknown dev
    {32'h8011_0004, 32'd40000000},  // R6
    {32'h8011_0005, 32'd50000000},  // R6
    {32'h8011_0006, 32'd35000000},  // R6
    {32'h8011_0007, 32'd40000000},  // R6
    {32'h8011_0008, 32'd40000000},  // R6
    {32'h8011_0009, 32'd0},         // R6
    {32'h8012_0000, SENT},          // R7 site2
    {32'h8013_0001, SENT},          // R7 site3
    {32'h8010_1000, SENT},          // R8 position 1
    {32'h8020_0000, SENT},          // R8 function 2
    {32'h8410_0000, SENT},          // R8 index 1
    {32'hC010_0000, SENT},          // R10 write flag
    {32'h0010_0000, SENT}           // R9 start clear
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        req_pulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osc_query_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_pulse(req_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic p);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    p = req_pulse;
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic p;
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", {31'd0, req_pulse}, 32'd0);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_DATA, r);
    check("R1 data after reset", r, 32'd0);
    check("R1 pulse after reset", {31'd0, req_pulse}, 32'd0);

    wr(A_DATA, 32'hA5C3_0F96, p);
    rd(A_DATA, r);
    check("R2 data readback", r, 32'hA5C3_0F96);
    rd(A_CTRL, r);
    check("R3 ctrl read", r, 32'd0);
    rd(A_STAT, r);
    check("R3 stat read", r, 32'd1);
    rd(8'h10, r);
    check("R4 unmapped read", r, 32'd0);
    wr(8'h10, 32'h1234_5678, p);
    wr(A_STAT, 32'h8765_4321, p);
    rd(A_DATA, r);
    check("R4 stray writes", r, 32'hA5C3_0F96);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] cw, ex;
      cw = VEC[i][63:32];
      ex = VEC[i][31:0];
      wr(A_DATA, SENT, p);
      wr(A_CTRL, cw, p);
      check($sformatf("R11 pulse vec %0d", i), {31'd0, p}, {31'd0, cw[31]});
      @(negedge clk);
      check($sformatf("R11 pulse drop vec %0d", i), {31'd0, req_pulse}, 32'd0);
      rd(A_DATA, r);
      check($sformatf("R5-8 lookup vec %0d", i), r, ex);
    end

    // R11: back-to-back starts give back-to-back pulses, result visible at once
    wr(A_DATA, SENT, p);
    bus_addr = A_CTRL; bus_we = 1'b1; bus_wdata = 32'h8010_0002;
    @(posedge clk); @(negedge clk);
    check("R11 first pulse", {31'd0, req_pulse}, 32'd1);
    bus_wdata = 32'h8011_0006; bus_addr = A_CTRL;
    @(posedge clk); @(negedge clk);
    check("R11 second pulse", {31'd0, req_pulse}, 32'd1);
    bus_we = 1'b0; bus_addr = A_DATA;
    @(posedge clk); @(negedge clk);
    check("R11 pulse ends", {31'd0, req_pulse}, 32'd0);
    check("R6 latest result", bus_rdata, 32'd35000000);

    // R1: reset mid-run clears stored data
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(A_DATA, r);
    check("R1 data cleared", r, 32'd0);

    finish_run();
  end

endmodule